// File: doc/BRIEF.md
# Programmable Pin Edge Interrupt Detector

This block watches a set of external pins (four by default) and raises a request on one channel for one clock cycle when that channel's pin shows an edge it has been told to look for. Each channel gets its edge choice from two bits at the same index in two control registers. One register holds the rising-edge enables and the other holds the falling-edge enables. The two bits together give four modes: off, falling only, rising only, or both edges. The four mode values EM_OFF, EM_FALL, EM_RISE and EM_BOTH are the states of each channel's decode. A channel moves between them only when software writes its bits, and it takes the new state at the clock edge that completes the write.

Each pin goes through a chain of synchroniser flops. A history flop then holds the synchronised level from one cycle earlier. A difference between the two is classified as EV_UP or EV_DOWN, and EV_NONE means no change. The classification is compared with the channel's mode, and a match loads the request flop. A per-channel input-mode gate blocks requests on pins that are not in input mode. The history flop still follows the pin while the gate is low. Software reaches the registers through a small bus that offers whole-byte writes, single-bit set/clear writes and combinational byte reads. Before software turns a pin into an output, it should clear both enable bits for that channel, because the direction change can look like an edge.

Top module: `pin_edge_irq`

## Requirements
- R1: Directly after reset both control registers read 0x00 and no request output is high.
- R2: A channel with rising bit 0 and falling bit 0 (code 00) never raises a request, whatever its pin does.
- R3: Code 01 (rising bit 0, falling bit 1) raises a request for each high-to-low pin transition and none for low-to-high.
- R4: Code 10 (rising bit 1, falling bit 0) raises a request for each low-to-high pin transition and none for high-to-low.
- R5: Code 11 raises a request for every pin transition in either direction.
- R6: A byte write stores data bits 3..0 into bits for channels 0..3. Bits 7..4 always read as 0, and writes to them have no effect.
- R7: A single-bit write (bit_op=1) at bit index i writes data bit 0 into bit i of the addressed register and leaves every other bit unchanged. An index of 4 or more changes nothing.
- R8: Offset 0 is the rising-enable register and offset 1 is the falling-enable register. Offsets 2 and 3 read 0x00 and ignore writes.
- R9: A pin change that is set up before clock edge k produces a request that is high for exactly the one cycle after edge k+2, with the default two synchroniser stages.
- R10: While a channel's input-mode gate is low it raises no request. Its edge history keeps tracking the pin, so raising the gate again with the pin unchanged raises no request.
- R11: A write to the enable bits affects detection from the cycle after the write. An edge that is judged in the same cycle as the write uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 4 | Raw external pins, one per channel |
| in_mode | input | 4 | Per-channel gate: 1 = pin is in input mode |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_bit_op | input | 1 | 1 = single-bit write, 0 = byte write |
| bus_bit_idx | input | 3 | Bit index for a single-bit write |
| bus_wdata | input | 8 | Write data; bit 0 is the value for a single-bit write |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 4 | One-cycle request pulse per channel |

## Verification
The bench builds the block with its defaults: four channels, an 8-bit data path, a 2-bit offset and two synchroniser stages. Two offsets are left over at that width, so the reads and writes that must decode to nothing can be exercised. The data path leaves four reserved bits for masking checks. The short synchroniser makes the same-cycle write race of R11 easy to line up by counting edges. A behavioural model in the bench predicts every request and every read value cycle by cycle, and directed passes walk all four codes on all four channels.

// File: rtl/pei_pkg.sv
package pei_pkg;

    typedef enum logic [1:0] {
        EM_OFF  = 2'b00,
        EM_FALL = 2'b01,
        EM_RISE = 2'b10,
        EM_BOTH = 2'b11
    } edge_mode_t;

    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_UP   = 2'b01,
        EV_DOWN = 2'b10
    } edge_event_t;

    function automatic edge_mode_t mode_of(input logic rise_bit, input logic fall_bit);
        return edge_mode_t'({rise_bit, fall_bit});
    endfunction

endpackage

// File: rtl/pei_cfg_regs.sv
module pei_cfg_regs #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_bit_op,
    input  logic [$clog2(DATA_W)-1:0]  bus_bit_idx,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_CH-1:0]          rise_en,
    output logic [NUM_CH-1:0]          fall_en
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int PAD_W = DATA_W - NUM_CH;
    localparam logic [ADDR_W-1:0] OFS_RISE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_FALL = ADDR_W'(1);

    logic [NUM_CH-1:0] rise_q, fall_q;
    logic [NUM_CH-1:0] bit_mask;
    logic              idx_ok;
    logic              hit_rise, hit_fall;

    assign hit_rise = bus_wr && (bus_addr == OFS_RISE);
    assign hit_fall = bus_wr && (bus_addr == OFS_FALL);
    assign idx_ok   = (32'(bus_bit_idx) < NUM_CH);

    always_comb begin
        bit_mask = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_bit_idx == IDX_W'(i)) bit_mask[i] = 1'b1;
        end
    end

    function automatic logic [NUM_CH-1:0] next_val(
        input logic [NUM_CH-1:0] cur,
        input logic              bit_op,
        input logic              ok,
        input logic [NUM_CH-1:0] mask,
        input logic [DATA_W-1:0] wd
    );
        logic [NUM_CH-1:0] r;
        if (!bit_op)      r = wd[NUM_CH-1:0];
        else if (!ok)     r = cur;
        else if (wd[0])   r = cur | mask;
        else              r = cur & ~mask;
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            if (hit_rise) rise_q <= next_val(rise_q, bus_bit_op, idx_ok, bit_mask, bus_wdata);
            if (hit_fall) fall_q <= next_val(fall_q, bus_bit_op, idx_ok, bit_mask, bus_wdata);
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_RISE: bus_rdata = {{PAD_W{1'b0}}, rise_q};
            OFS_FALL: bus_rdata = {{PAD_W{1'b0}}, fall_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign rise_en = rise_q;
    assign fall_en = fall_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rise_q == '0 && fall_q == '0));

    // R7
    bit_write_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rise && bus_bit_op) |=> ((rise_q & ~$past(bit_mask)) == ($past(rise_q) & ~$past(bit_mask))));

    // R8
    stray_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != OFS_RISE && bus_addr != OFS_FALL) |=> ($stable(rise_q) && $stable(fall_q)));

endmodule

// File: rtl/pei_pin_sync.sv
module pei_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_raw};
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pei_edge_chan.sv
module pei_edge_chan
    import pei_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_bit,
    input  logic fall_bit,
    input  logic gate,
    output logic req
);
    logic        prev_q;
    logic        req_q;
    logic        hit;
    edge_mode_t  mode;
    edge_event_t ev;

    assign mode = mode_of(rise_bit, fall_bit);

    always_comb begin
        if (lvl == prev_q) ev = EV_NONE;
        else if (lvl)      ev = EV_UP;
        else               ev = EV_DOWN;
    end

    always_comb begin
        unique case (mode)
            EM_OFF:  hit = 1'b0;
            EM_FALL: hit = (ev == EV_DOWN);
            EM_RISE: hit = (ev == EV_UP);
            EM_BOTH: hit = (ev != EV_NONE);
            default: hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= hit && gate;
    end

    assign req = req_q;

    // R2
    off_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ($past(rise_bit) || $past(fall_bit)));

    // R10
    gate_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(gate));

    // R9
    req_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ($past(lvl) != $past(lvl, 2)));

    // R3
    fall_only_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(mode) == EM_FALL) |-> !$past(lvl));

    // R4
    rise_only_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(mode) == EM_RISE) |-> $past(lvl));

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          pin_in,
    input  logic [NUM_CH-1:0]          in_mode,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_bit_op,
    input  logic [$clog2(DATA_W)-1:0]  bus_bit_idx,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_CH-1:0]          irq
);
    logic [NUM_CH-1:0] rise_en, fall_en, lvl;

    pei_cfg_regs #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_bit_op(bus_bit_op),
        .bus_bit_idx(bus_bit_idx), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rise_en(rise_en), .fall_en(fall_en)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            pei_pin_sync #(.STAGES(STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .pin_raw(pin_in[c]), .pin_sync(lvl[c])
            );
            pei_edge_chan u_chan (
                .clk(clk), .rst_n(rst_n), .lvl(lvl[c]),
                .rise_bit(rise_en[c]), .fall_bit(fall_en[c]),
                .gate(in_mode[c]), .req(irq[c])
            );
        end
    endgenerate

    // R6
    reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_CH] == '0);

    // R1
    reset_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> irq == '0);

endmodule

// File: tb/sim_pin_edge_irq.sv
module sim_pin_edge_irq;
    localparam int NC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_in = '0, in_mode = '0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_bit_op = 1'b0;
    logic [2:0] bus_bit_idx = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] irq;

    int checks = 0, errors = 0;
    bit done = 0;
    int pulse_cnt [NC];

    // behavioural reference state
    bit m_pipe [NC][$];
    bit m_prev [NC];
    bit m_irq  [NC];
    int m_rise = 0, m_fall = 0;

    always #4 clk = ~clk;

    pin_edge_irq u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .in_mode(in_mode),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_bit_op(bus_bit_op),
        .bus_bit_idx(bus_bit_idx), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int apply_wr(int cur);
        int r = cur;
        if (!bus_bit_op) r = bus_wdata & 8'h0F;
        else if (bus_bit_idx < 4) begin
            if (bus_wdata[0]) r = cur | (1 << bus_bit_idx);
            else              r = cur & ~(1 << bus_bit_idx);
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                m_pipe[c] = '{0, 0};
                m_prev[c] = 0;
                m_irq[c]  = 0;
            end
            m_rise = 0;
            m_fall = 0;
        end else begin
            for (int c = 0; c < NC; c++) begin
                bit lv;
                lv = m_pipe[c][0];
                m_irq[c] = in_mode[c] && (lv != m_prev[c]) &&
                           ((lv && m_rise[c]) || (!lv && m_fall[c]));
                m_prev[c] = lv;
                void'(m_pipe[c].pop_front());
                m_pipe[c].push_back(pin_in[c]);
            end
            if (bus_wr && bus_addr == 2'd0) m_rise = apply_wr(m_rise);
            else if (bus_wr && bus_addr == 2'd1) m_fall = apply_wr(m_fall);
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always begin
        @(posedge clk);
        #5;
        if (rst_n && !done) begin
            int er;
            for (int c = 0; c < NC; c++) begin
                check("R9", irq[c], m_irq[c]);
                if (irq[c]) pulse_cnt[c]++;
            end
            er = (bus_addr == 2'd0) ? m_rise : (bus_addr == 2'd1) ? m_fall : 0;
            check("R8", bus_rdata, er);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(bit [1:0] a, bit bop, bit [2:0] idx, bit [7:0] d);
        bus_addr = a; bus_bit_op = bop; bus_bit_idx = idx; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_bit_op = 1'b0;
    endtask

    task automatic rd_check(string req, bit [1:0] a, int exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic clear_counts();
        for (int c = 0; c < NC; c++) pulse_cnt[c] = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string tags [4];
        tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";
        clear_counts();
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1: reset state
        rd_check("R1", 2'd0, 0);
        rd_check("R1", 2'd1, 0);
        check("R1", irq, 0);
        in_mode = 4'hF;

        // R2 R3 R4 R5: every code on every channel
        for (int c = 0; c < NC; c++) begin
            for (int m = 0; m < 4; m++) begin
                wr(2'd0, 1'b1, 3'(c), 8'(m >> 1));
                wr(2'd1, 1'b1, 3'(c), 8'(m & 1));
                tick(2);
                clear_counts();
                pin_in[c] = 1'b1;
                tick(6);
                pin_in[c] = 1'b0;
                tick(6);
                check(tags[m], pulse_cnt[c], (m >> 1) + (m & 1));
            end
        end

        // R6: byte writes, reserved bits
        wr(2'd0, 1'b0, 3'd0, 8'hFF);
        rd_check("R6", 2'd0, 8'h0F);
        wr(2'd1, 1'b0, 3'd0, 8'hA5);
        rd_check("R6", 2'd1, 8'h05);

        // R7: bit set/clear, out-of-range index
        wr(2'd1, 1'b1, 3'd1, 8'h01);
        rd_check("R7", 2'd1, 8'h07);
        wr(2'd1, 1'b1, 3'd0, 8'h00);
        rd_check("R7", 2'd1, 8'h06);
        wr(2'd0, 1'b1, 3'd6, 8'h00);
        rd_check("R7", 2'd0, 8'h0F);
        wr(2'd0, 1'b1, 3'd3, 8'hFE);
        rd_check("R7", 2'd0, 8'h07);

        // R8: unused offsets
        wr(2'd2, 1'b0, 3'd0, 8'hFF);
        wr(2'd3, 1'b1, 3'd0, 8'h01);
        rd_check("R8", 2'd2, 0);
        rd_check("R8", 2'd3, 0);
        rd_check("R8", 2'd0, 8'h07);
        rd_check("R8", 2'd1, 8'h06);

        // R10: gate low suppresses, history keeps tracking
        wr(2'd0, 1'b0, 3'd0, 8'h0F);
        wr(2'd1, 1'b0, 3'd0, 8'h0F);
        tick(2);
        clear_counts();
        in_mode[2] = 1'b0;
        pin_in[2] = 1'b1;
        tick(6);
        check("R10", pulse_cnt[2], 0);
        in_mode[2] = 1'b1;
        tick(6);
        check("R10", pulse_cnt[2], 0);
        pin_in[2] = 1'b0;
        tick(6);
        check("R10", pulse_cnt[2], 1);

        // R11: write in the judging cycle uses the old setting
        wr(2'd0, 1'b0, 3'd0, 8'h00);
        wr(2'd1, 1'b0, 3'd0, 8'h00);
        tick(2);
        clear_counts();
        pin_in[1] = 1'b1;
        tick(2);
        wr(2'd0, 1'b0, 3'd0, 8'h0F);
        tick(4);
        check("R11", pulse_cnt[1], 0);
        clear_counts();
        pin_in[1] = 1'b0;
        tick(6);
        check("R11", pulse_cnt[1], 0);
        pin_in[1] = 1'b1;
        tick(2);
        wr(2'd0, 1'b0, 3'd0, 8'h00);
        tick(4);
        check("R11", pulse_cnt[1], 1);

        // R9: both-edge toggling every cycle gives back-to-back pulses
        wr(2'd0, 1'b0, 3'd0, 8'h01);
        wr(2'd1, 1'b0, 3'd0, 8'h01);
        tick(2);
        clear_counts();
        for (int k = 0; k < 5; k++) begin
            pin_in[0] = ~pin_in[0];
            tick();
        end
        tick(6);
        check("R9", pulse_cnt[0], 5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule